// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the frequencies that a clock tree delivers to its bus domain, its register-interface domain and its peripheral-timer domain. It starts from a fixed 24 MHz reference and walks the tree in order. A system PLL multiplies the reference by 22 or by 20. Two fractional dividers derive further clocks from the PLL. Two multiplexers select the peripheral root. Three integer post-dividers then produce the bus clock, the register-interface clock and the timer clock.

The caller presents the selection and divider fields and pulses `start`. The block samples every field on that edge and runs five divisions in a fixed order through one shared bit-serial unsigned divider. It then updates all three results together, pulses `done` for one cycle and reports, through `err`, whether the selected path used a reserved or undefined setting. The result registers keep their values until the next computation finishes.

Top module: `clk_freq_calc`

## Requirements
- R1: After reset, `bus_hz`, `ipg_hz` and `per_hz` are 0, and `done`, `busy` and `err` are 0.
- R2: The system PLL frequency is 24 000 000 × 22 when `sys_div22` is 1 and 24 000 000 × 20 when it is 0. With `pre_sel` = 0 and `periph_sel` = 0, this frequency is the peripheral root.
- R3: Each fractional output is PLL × 18 / frac. With `periph_sel` = 0, `pre_sel` = 1 selects floor(PLL × 18 / `frac2`), `pre_sel` = 2 selects floor(PLL × 18 / `frac0`), and `pre_sel` = 3 selects floor(PLL × 18 / (2 × `frac2`)).
- R4: When `periph_sel` = 0 and the fractional field that `pre_sel` uses is 0, no division by that field takes place. The peripheral root is 0 and `err` is 1 with `done`.
- R5: With `periph_sel` = 1, the root is the alternate source divided by (`alt_podf`+1). The source is 480 000 000 for `alt_sel` = 0, 24 000 000 for `alt_sel` = 1, and 0 for `alt_sel` = 2.
- R6: `alt_sel` = 3 is reserved. With `periph_sel` = 1 it yields a root of 0 and sets `err`. A setting on the path that `periph_sel` does not select never sets `err`.
- R7: `bus_hz` = floor(root / (`ahb_podf`+1)) and `ipg_hz` = floor(bus / (`ipg_podf`+1)).
- R8: The timer source is the register-interface clock when `per_sel` = 0 and 24 000 000 when `per_sel` = 1. `per_hz` = floor(source / (`per_podf`+1)).
- R9: All intermediate values are carried at `ACC_W` (64) bits. Each output is the low 32 bits of its full-width value.
- R10: `busy` is 1 from the cycle after an accepted `start` until completion. `done` is a one-cycle pulse exactly 5 × (`ACC_W`+2) cycles (330 by default) after the accepting edge. `busy` is 0 while `done` is 1.
- R11: Fields are sampled only on the accepting edge. Field changes and `start` pulses while `busy` is 1 have no effect. The outputs and `err` change only in the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| sys_div22 | input | 1 | System PLL multiplier select (1: ×22, 0: ×20) |
| frac0 | input | 6 | Fractional divider field for output 0 |
| frac2 | input | 6 | Fractional divider field for output 2 |
| pre_sel | input | 2 | Main-path source select |
| alt_sel | input | 2 | Alternate-path source select (3 reserved) |
| alt_podf | input | 3 | Alternate-path divider minus one |
| periph_sel | input | 1 | Root select (0 main, 1 alternate) |
| ahb_podf | input | 3 | Bus divider minus one |
| ipg_podf | input | 2 | Register-interface divider minus one |
| per_sel | input | 1 | Timer source select (0 interface clock, 1 reference) |
| per_podf | input | 6 | Timer divider minus one |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Selected path used a reserved or zero-fraction setting |
| bus_hz | output | 32 | Bus clock frequency in Hz |
| ipg_hz | output | 32 | Register-interface clock frequency in Hz |
| per_hz | output | 32 | Timer clock frequency in Hz |

## Verification
All three frequencies and `err` are due together, in a single cycle: 5 × (`ACC_W`+2) = 330 clock edges after the edge that accepts `start`. Each of the five divisions takes one launch edge, 64 iteration edges and one capture edge, whatever the field values are. The bench drives on falling edges and counts rising edges from the accepting edge until `done` appears. It requires that count to equal 330 exactly, and it compares all outputs at that falling edge against values it computes itself at 64 bits. For the test of ignored fields, the count starts from the original `start`, so a restart that was wrongly accepted would show up as a different latency or different results.

// File: rtl/clk_freq_pkg.sv
package clk_freq_pkg;

   // Division stages, in the order the tree is walked
   typedef enum logic [2:0] {
      STG_PRE = 3'd0,
      STG_ALT = 3'd1,
      STG_AHB = 3'd2,
      STG_IPG = 3'd3,
      STG_PER = 3'd4
   } stage_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_LAUNCH = 2'd1,
      PH_WAIT   = 2'd2
   } phase_e;

   localparam int unsigned STAGE_COUNT = 5;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clk_freq_div.sv
// Restoring bit-serial unsigned divider: one quotient bit per cycle.
module clk_freq_div #(
   parameter int unsigned NW = 64,
   parameter int unsigned DW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          busy,
   output logic          done,
   output logic [NW-1:0] quo
);
   localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1;

   logic [NW-1:0] q_r;
   logic [DW-1:0] r_r;
   logic [DW-1:0] d_r;
   logic [CW-1:0] cnt_r;
   logic          busy_r;
   logic          done_r;

   logic [DW:0]   trial;
   logic [DW:0]   diff;
   logic          ge;

   always_comb begin
      trial = {r_r, q_r[NW-1]};
      diff  = trial - {1'b0, d_r};
      ge    = ~diff[DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         r_r    <= '0;
         d_r    <= '0;
         cnt_r  <= '0;
         busy_r <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (start && !busy_r) begin
            q_r    <= num;
            r_r    <= '0;
            d_r    <= den;
            cnt_r  <= '0;
            busy_r <= 1'b1;
         end else if (busy_r) begin
            r_r   <= ge ? diff[DW-1:0] : trial[DW-1:0];
            q_r   <= {q_r[NW-2:0], ge};
            cnt_r <= cnt_r + CW'(1);
            if (cnt_r == CW'(NW - 1)) begin
               busy_r <= 1'b0;
               done_r <= 1'b1;
            end
         end
      end
   end

   assign busy = busy_r;
   assign done = done_r;
   assign quo  = q_r;

endmodule

// File: rtl/clk_freq_src.sv
// Picks dividend and divisor for the current stage, and flags bad selections.
module clk_freq_src
   import clk_freq_pkg::*;
#(
   parameter int unsigned REF_HZ     = 24000000,
   parameter int unsigned SYS_MUL_HI = 22,
   parameter int unsigned SYS_MUL_LO = 20,
   parameter int unsigned USB_MUL    = 20,
   parameter int unsigned FRAC_NUM   = 18,
   parameter int unsigned ACC_W      = 64,
   parameter int unsigned DVW        = 7,
   parameter int unsigned FRAC_W     = 6,
   parameter int unsigned ALT_PODF_W = 3,
   parameter int unsigned AHB_PODF_W = 3,
   parameter int unsigned IPG_PODF_W = 2,
   parameter int unsigned PER_PODF_W = 6
) (
   input  stage_e                 stage,
   input  logic                   sys_div22,
   input  logic [FRAC_W-1:0]      frac0,
   input  logic [FRAC_W-1:0]      frac2,
   input  logic [1:0]             pre_sel,
   input  logic [1:0]             alt_sel,
   input  logic [ALT_PODF_W-1:0]  alt_podf,
   input  logic                   periph_sel,
   input  logic [AHB_PODF_W-1:0]  ahb_podf,
   input  logic [IPG_PODF_W-1:0]  ipg_podf,
   input  logic                   per_sel,
   input  logic [PER_PODF_W-1:0]  per_podf,
   input  logic [ACC_W-1:0]       pre_q,
   input  logic [ACC_W-1:0]       alt_q,
   input  logic [ACC_W-1:0]       ahb_q,
   input  logic [ACC_W-1:0]       ipg_q,
   output logic [ACC_W-1:0]       num,
   output logic [DVW-1:0]         den,
   output logic                   cfg_err
);
   localparam longint unsigned SYS_HI = longint'(REF_HZ) * longint'(SYS_MUL_HI);
   localparam longint unsigned SYS_LO = longint'(REF_HZ) * longint'(SYS_MUL_LO);
   localparam logic [ACC_W-1:0] REF_V    = ACC_W'(longint'(REF_HZ));
   localparam logic [ACC_W-1:0] USB_V    = ACC_W'(longint'(REF_HZ) * longint'(USB_MUL));
   localparam logic [ACC_W-1:0] SYS_HI_V = ACC_W'(SYS_HI);
   localparam logic [ACC_W-1:0] SYS_LO_V = ACC_W'(SYS_LO);
   localparam logic [ACC_W-1:0] FR_HI_V  = ACC_W'(SYS_HI * longint'(FRAC_NUM));
   localparam logic [ACC_W-1:0] FR_LO_V  = ACC_W'(SYS_LO * longint'(FRAC_NUM));

   logic [FRAC_W-1:0] f_use;
   logic              pre_err;
   logic              alt_err;
   logic [ACC_W-1:0]  sys_v;
   logic [ACC_W-1:0]  sys_fr;

   always_comb begin
      f_use   = (pre_sel == 2'd2) ? frac0 : frac2;
      pre_err = (pre_sel != 2'd0) && (f_use == '0);
      alt_err = (alt_sel == 2'd3);
      cfg_err = periph_sel ? alt_err : pre_err;
      sys_v   = sys_div22 ? SYS_HI_V : SYS_LO_V;
      sys_fr  = sys_div22 ? FR_HI_V : FR_LO_V;
   end

   always_comb begin
      num = '0;
      den = DVW'(1);
      unique case (stage)
         STG_PRE: begin
            if (pre_sel == 2'd0) begin
               num = sys_v;
            end else if (!pre_err) begin
               num = sys_fr;
               // halving after the fraction folds into a doubled divisor
               den = (pre_sel == 2'd3) ? DVW'({f_use, 1'b0}) : DVW'(f_use);
            end
         end
         STG_ALT: begin
            unique case (alt_sel)
               2'd0:    num = USB_V;
               2'd1:    num = REF_V;
               default: num = '0;
            endcase
            den = DVW'(alt_podf) + DVW'(1);
         end
         STG_AHB: begin
            num = periph_sel ? alt_q : pre_q;
            den = DVW'(ahb_podf) + DVW'(1);
         end
         STG_IPG: begin
            num = ahb_q;
            den = DVW'(ipg_podf) + DVW'(1);
         end
         STG_PER: begin
            num = per_sel ? REF_V : ipg_q;
            den = DVW'(per_podf) + DVW'(1);
         end
         default: begin
            num = '0;
            den = DVW'(1);
         end
      endcase
   end

endmodule

// File: rtl/clk_freq_calc.sv
module clk_freq_calc
   import clk_freq_pkg::*;
#(
   parameter int unsigned REF_HZ     = 24000000,
   parameter int unsigned SYS_MUL_HI = 22,
   parameter int unsigned SYS_MUL_LO = 20,
   parameter int unsigned USB_MUL    = 20,
   parameter int unsigned FRAC_NUM   = 18,
   parameter int unsigned ACC_W      = 64,
   parameter int unsigned OUT_W      = 32,
   parameter int unsigned FRAC_W     = 6,
   parameter int unsigned ALT_PODF_W = 3,
   parameter int unsigned AHB_PODF_W = 3,
   parameter int unsigned IPG_PODF_W = 2,
   parameter int unsigned PER_PODF_W = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   sys_div22,
   input  logic [FRAC_W-1:0]      frac0,
   input  logic [FRAC_W-1:0]      frac2,
   input  logic [1:0]             pre_sel,
   input  logic [1:0]             alt_sel,
   input  logic [ALT_PODF_W-1:0]  alt_podf,
   input  logic                   periph_sel,
   input  logic [AHB_PODF_W-1:0]  ahb_podf,
   input  logic [IPG_PODF_W-1:0]  ipg_podf,
   input  logic                   per_sel,
   input  logic [PER_PODF_W-1:0]  per_podf,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic [OUT_W-1:0]       bus_hz,
   output logic [OUT_W-1:0]       ipg_hz,
   output logic [OUT_W-1:0]       per_hz
);
   localparam int unsigned DVW = max_u(max_u(FRAC_W + 1, ALT_PODF_W + 1),
                                       max_u(max_u(AHB_PODF_W + 1, IPG_PODF_W + 1),
                                             PER_PODF_W + 1));

   // elaboration-time parameter checks
   if (OUT_W > ACC_W) begin : g_bad_out_w
      $error("OUT_W must not exceed ACC_W");
   end
   if (ACC_W > 64 || ACC_W < 2) begin : g_bad_acc_w
      $error("ACC_W must lie in 2..64");
   end
   if (FRAC_W < 1) begin : g_bad_frac_w
      $error("FRAC_W must be at least 1");
   end

   // sampled configuration
   logic                  c_div22, c_psel, c_persel;
   logic [FRAC_W-1:0]     c_f0, c_f2;
   logic [1:0]            c_pre, c_alt;
   logic [ALT_PODF_W-1:0] c_altp;
   logic [AHB_PODF_W-1:0] c_ahb;
   logic [IPG_PODF_W-1:0] c_ipg;
   logic [PER_PODF_W-1:0] c_perp;

   phase_e             phase;
   stage_e             stage;
   logic [ACC_W-1:0]   pre_q, alt_q, ahb_q, ipg_q;
   logic [ACC_W-1:0]   dv_num, dv_quo;
   logic [DVW-1:0]     dv_den;
   logic               dv_busy, dv_done, cfg_err;

   clk_freq_src #(
      .REF_HZ(REF_HZ), .SYS_MUL_HI(SYS_MUL_HI), .SYS_MUL_LO(SYS_MUL_LO),
      .USB_MUL(USB_MUL), .FRAC_NUM(FRAC_NUM), .ACC_W(ACC_W), .DVW(DVW),
      .FRAC_W(FRAC_W), .ALT_PODF_W(ALT_PODF_W), .AHB_PODF_W(AHB_PODF_W),
      .IPG_PODF_W(IPG_PODF_W), .PER_PODF_W(PER_PODF_W)
   ) u_src (
      .stage(stage), .sys_div22(c_div22), .frac0(c_f0), .frac2(c_f2),
      .pre_sel(c_pre), .alt_sel(c_alt), .alt_podf(c_altp), .periph_sel(c_psel),
      .ahb_podf(c_ahb), .ipg_podf(c_ipg), .per_sel(c_persel), .per_podf(c_perp),
      .pre_q(pre_q), .alt_q(alt_q), .ahb_q(ahb_q), .ipg_q(ipg_q),
      .num(dv_num), .den(dv_den), .cfg_err(cfg_err)
   );

   clk_freq_div #(.NW(ACC_W), .DW(DVW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(phase == PH_LAUNCH),
      .num(dv_num), .den(dv_den), .busy(dv_busy), .done(dv_done), .quo(dv_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         stage    <= STG_PRE;
         c_div22  <= 1'b0;
         c_psel   <= 1'b0;
         c_persel <= 1'b0;
         c_f0     <= '0;
         c_f2     <= '0;
         c_pre    <= '0;
         c_alt    <= '0;
         c_altp   <= '0;
         c_ahb    <= '0;
         c_ipg    <= '0;
         c_perp   <= '0;
         pre_q    <= '0;
         alt_q    <= '0;
         ahb_q    <= '0;
         ipg_q    <= '0;
         bus_hz   <= '0;
         ipg_hz   <= '0;
         per_hz   <= '0;
         err      <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  c_div22  <= sys_div22;
                  c_f0     <= frac0;
                  c_f2     <= frac2;
                  c_pre    <= pre_sel;
                  c_alt    <= alt_sel;
                  c_altp   <= alt_podf;
                  c_psel   <= periph_sel;
                  c_ahb    <= ahb_podf;
                  c_ipg    <= ipg_podf;
                  c_persel <= per_sel;
                  c_perp   <= per_podf;
                  stage    <= STG_PRE;
                  phase    <= PH_LAUNCH;
               end
            end
            PH_LAUNCH: phase <= PH_WAIT;
            PH_WAIT: begin
               if (dv_done && !dv_busy) begin
                  phase <= PH_LAUNCH;
                  unique case (stage)
                     STG_PRE: begin pre_q <= dv_quo; stage <= STG_ALT; end
                     STG_ALT: begin alt_q <= dv_quo; stage <= STG_AHB; end
                     STG_AHB: begin ahb_q <= dv_quo; stage <= STG_IPG; end
                     STG_IPG: begin ipg_q <= dv_quo; stage <= STG_PER; end
                     default: begin
                        bus_hz <= ahb_q[OUT_W-1:0];
                        ipg_hz <= ipg_q[OUT_W-1:0];
                        per_hz <= dv_quo[OUT_W-1:0];
                        err    <= cfg_err;
                        done   <= 1'b1;
                        stage  <= STG_PRE;
                        phase  <= PH_IDLE;
                     end
                  endcase
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/clk_freq_calc_chk.sv
module clk_freq_calc_chk #(
   parameter int unsigned ACC_W = 64,
   parameter int unsigned OUT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             err,
   input logic [OUT_W-1:0] bus_hz,
   input logic [OUT_W-1:0] ipg_hz,
   input logic [OUT_W-1:0] per_hz
);
   localparam logic [15:0] LAT_CYC = 16'(5 * (ACC_W + 2));

   logic [15:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (start && !busy)   lat_cnt <= '0;
      else if (busy)             lat_cnt <= lat_cnt + 16'd1;
   end

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                        // R10
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R10
   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == LAT_CYC));                                    // R10
   AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(bus_hz) && $stable(ipg_hz) && $stable(per_hz) && $stable(err))); // R11
   AST_ERR_ZERO_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (bus_hz == '0 && ipg_hz == '0));                 // R6

endmodule

bind clk_freq_calc clk_freq_calc_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
   .bus_hz(bus_hz), .ipg_hz(ipg_hz), .per_hz(per_hz)
);

// File: tb/clk_freq_calc_tb.sv
`timescale 1ns/1ps
module clk_freq_calc_tb;
   localparam int LAT = 5 * (64 + 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic s_div22 = 1'b1, s_psel = 1'b0, s_persel = 1'b0;
   logic [5:0] s_f0 = 6'd19, s_f2 = 6'd24, s_perp = 6'd0;
   logic [1:0] s_pre = 2'd0, s_alt = 2'd0, s_ipg = 2'd0;
   logic [2:0] s_altp = 3'd0, s_ahb = 3'd0;
   logic busy, done, err;
   logic [31:0] bus_hz, ipg_hz, per_hz;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   clk_freq_calc u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .sys_div22(s_div22),
      .frac0(s_f0), .frac2(s_f2), .pre_sel(s_pre), .alt_sel(s_alt),
      .alt_podf(s_altp), .periph_sel(s_psel), .ahb_podf(s_ahb),
      .ipg_podf(s_ipg), .per_sel(s_persel), .per_podf(s_perp),
      .busy(busy), .done(done), .err(err),
      .bus_hz(bus_hz), .ipg_hz(ipg_hz), .per_hz(per_hz)
   );

   task automatic check(input string tag, input string what,
                        input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic void model(output logic [31:0] eb, output logic [31:0] ei,
                                 output logic [31:0] ep, output logic ee);
      longint unsigned sys, pre, alt, root, ahb, ipg, psrc, per;
      logic [5:0] f;
      logic pe, ae;
      sys = 64'd24000000 * (s_div22 ? 64'd22 : 64'd20);
      f   = (s_pre == 2'd2) ? s_f0 : s_f2;
      pe  = (s_pre != 2'd0) && (f == 6'd0);
      if (s_pre == 2'd0)      pre = sys;
      else if (pe)            pre = 0;
      else if (s_pre == 2'd3) pre = (sys * 18 / f) / 2;
      else                    pre = sys * 18 / f;
      ae = (s_alt == 2'd3);
      case (s_alt)
         2'd0:    alt = 64'd480000000;
         2'd1:    alt = 64'd24000000;
         default: alt = 0;
      endcase
      alt  = alt / (longint'(s_altp) + 1);
      root = s_psel ? alt : pre;
      ee   = s_psel ? ae : pe;
      ahb  = root / (longint'(s_ahb) + 1);
      ipg  = ahb / (longint'(s_ipg) + 1);
      psrc = s_persel ? 64'd24000000 : ipg;
      per  = psrc / (longint'(s_perp) + 1);
      eb = ahb[31:0];
      ei = ipg[31:0];
      ep = per[31:0];
   endfunction

   // Pulse start, count rising edges until done, and compare everything.
   task automatic run_case(input string tag);
      logic [31:0] eb, ei, ep;
      logic ee;
      int k;
      model(eb, ei, ep, ee);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10", "busy after start", busy, 1);
      k = 0;
      while (!done && k < LAT + 50) begin
         @(posedge clk);
         @(negedge clk);
         k++;
      end
      check("R10", "latency", k, LAT);
      check(tag, "bus_hz", bus_hz, eb);
      check(tag, "ipg_hz", ipg_hz, ei);
      check(tag, "per_hz", per_hz, ep);
      check(tag, "err", err, ee);
   endtask

   task automatic base_cfg();
      s_div22 = 1'b1; s_f0 = 6'd19; s_f2 = 6'd24; s_pre = 2'd0; s_alt = 2'd0;
      s_altp = 3'd0; s_psel = 1'b0; s_ahb = 3'd0; s_ipg = 2'd0;
      s_persel = 1'b0; s_perp = 6'd0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] eb, ei, ep;
      logic ee;
      int k;
      int fr[5] = '{0, 1, 7, 35, 63};

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "bus_hz", bus_hz, 0);
      check("R1", "ipg_hz", ipg_hz, 0);
      check("R1", "per_hz", per_hz, 0);
      check("R1", "done", done, 0);
      check("R1", "busy", busy, 0);
      check("R1", "err", err, 0);
      rst_n = 1'b1;

      // R2/R3/R4: main path, both PLL multipliers, all four selections
      for (int d = 0; d < 2; d++) begin
         for (int p = 0; p < 4; p++) begin
            for (int j = 0; j < 5; j++) begin
               base_cfg();
               s_div22 = d[0];
               s_pre = p[1:0];
               s_f0 = fr[j][5:0];
               s_f2 = fr[(j + 2) % 5][5:0];
               s_ahb = 3'd3;
               s_ipg = 2'd1;
               model(eb, ei, ep, ee);
               if (p == 0)  run_case("R2");
               else if (ee) run_case("R4");
               else         run_case("R3");
            end
         end
      end

      // R5/R6: alternate path; main-path fractions are zero but unselected
      for (int a = 0; a < 4; a++) begin
         for (int q = 0; q < 8; q++) begin
            base_cfg();
            s_psel = 1'b1;
            s_pre = 2'd1;
            s_f0 = 6'd0;
            s_f2 = 6'd0;
            s_alt = a[1:0];
            s_altp = q[2:0];
            if (a == 3) run_case("R6");
            else        run_case("R5");
         end
      end

      // R6: reserved alternate setting while main path is selected
      base_cfg();
      s_alt = 2'd3;
      run_case("R6");

      // R7: bus and register-interface dividers
      for (int a = 0; a < 8; a++) begin
         for (int i = 0; i < 4; i++) begin
            base_cfg();
            s_ahb = a[2:0];
            s_ipg = i[1:0];
            run_case("R7");
         end
      end

      // R8: timer source and divider
      for (int s = 0; s < 2; s++) begin
         for (int pp = 0; pp < 64; pp += 9) begin
            base_cfg();
            s_ahb = 3'd2;
            s_ipg = 2'd3;
            s_persel = s[0];
            s_perp = pp[5:0];
            run_case("R8");
         end
      end

      // R9: 64-bit intermediate truncated only at the outputs
      base_cfg();
      s_pre = 2'd2;
      s_f0 = 6'd1;
      s_ipg = 2'd1;
      run_case("R9");
      check("R9", "bus_hz literal", bus_hz, 32'd914065408);
      check("R9", "ipg_hz literal", ipg_hz, 32'd457032704);

      // R10: done lasts one cycle
      @(negedge clk);
      check("R10", "done width", done, 0);

      // R11: field changes and a second start while busy are ignored
      base_cfg();
      s_pre = 2'd3;
      s_f2 = 6'd5;
      s_ahb = 3'd1;
      s_persel = 1'b1;
      s_perp = 6'd3;
      model(eb, ei, ep, ee);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      repeat (20) begin @(posedge clk); @(negedge clk); k++; end
      s_div22 = 1'b0; s_pre = 2'd0; s_psel = 1'b1; s_alt = 2'd3;
      s_ahb = 3'd7; s_ipg = 2'd3; s_persel = 1'b0; s_perp = 6'd0;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      k++;
      start = 1'b0;
      while (!done && k < LAT + 50) begin
         @(posedge clk);
         @(negedge clk);
         k++;
      end
      check("R11", "latency from first start", k, LAT);
      check("R11", "bus_hz", bus_hz, eb);
      check("R11", "ipg_hz", ipg_hz, ei);
      check("R11", "per_hz", per_hz, ep);
      check("R11", "err", err, ee);
      repeat (5) @(negedge clk);
      check("R11", "held bus_hz", bus_hz, eb);
      check("R11", "no second done", done, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule